// File: doc/BRIEF.md
# Damped Sliding DFT Bin Extractor

This block tracks one frequency bin of a sampled signal, by default the fundamental (bin 1), and gives its in-phase and quadrature parts again on every accepted sample. It works as a recursive sliding DFT. A comb stage subtracts a damped copy of the sample taken N strobes earlier. A complex single-pole resonator then rotates and accumulates the comb output. Because the damping factor sits slightly below one, rounding residue fades away over time and does not build up in the resonator.

All arithmetic is signed fixed point with 2 integer bits and 18 fractional bits. The twiddle constant r·e^(j2πk/N) and the comb weight r^N are worked out at elaboration from the parameters. The filter moves forward only on cycles where the sample strobe is high, so it can run at a low sample rate, such as 25.6 kHz, from a fast system clock. The user must keep the input amplitude small enough that the resonator stays inside its ±2 range. If it does not, the results saturate.

Top module: `sdft_bin`

## Requirements
- R1: While `rst_n` is low at a rising edge, both bin outputs go to zero, `bin_valid` goes low, the comb state is cleared and the sample history is treated as all zero.
- R2: `bin_valid` is high in exactly the cycle after each cycle in which `smp_en` was high, and low otherwise.
- R3: A cycle with `smp_en` low changes neither the bin outputs nor the filter state, whatever value is on `smp_in`.
- R4: On each strobe the resonator computes y[n] = W·(y[n-1] + c[n-1]), where W = Wr + j·Wi, Wr = r·cos(2πk/N) and Wi = r·sin(2πk/N). Each constant is quantised to 18 fractional bits by rounding to nearest, with ties away from zero. The real output is Wr·sr − Wi·si and the imaginary output is Wi·sr + Wr·si.
- R5: The comb output is c[n] = x[n] − RN·x[n−N], where RN is r^N quantised like the twiddle constants. Any sample position from before the N-th strobe after reset counts as zero.
- R6: Every value is signed 20-bit two's complement with 18 fractional bits. Each constant product is rounded by adding 2^17 and then shifting right arithmetically by 18. Every sum and product result saturates to the range [−2^19, 2^19−1].
- R7: The bin index k is a parameter with default 1. A tone at bin k builds a large output, while a tone at another bin stays small.
- R8: After a single impulse followed by zeros, the outputs fall to within a few LSB of zero once N+1 strobes have passed, because the damped comb cancels the resonator's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | Sample strobe; the filter advances when high |
| smp_in | input | W (20) | Signed input sample, 2.18 format |
| bin_re | output | W (20) | In-phase (real) part of the bin |
| bin_im | output | W (20) | Quadrature (imaginary) part of the bin |
| bin_valid | output | 1 | High for one cycle after each strobe |

## Verification
A wrong resonator state shows up on both outputs at the next valid pulse and stays there. It then fades only by the factor r on each strobe, so a bit-exact comparison exposes it at once. A fault in the delay line or the comb weight stays hidden for the first N strobes, because the history reads as zero until then. It appears only after N+1 strobes, when an impulse fails to cancel. For that reason the impulse test runs well beyond N samples. Errors in the strobe gating appear as output changes, or as valid pulses, on idle cycles.

// File: rtl/sdft_pkg.sv
// Shared helpers for the damped sliding DFT: elaboration-time constant
// quantisation and the rounding / saturation used by every datapath stage.
// Assumes all operands fit in 64-bit signed arithmetic (true for W <= 30).
package sdft_pkg;

    localparam real PI_R = 3.14159265358979323846;

    // Quantise a real constant to 'frac' fractional bits, ties away from zero.
    function automatic longint q_of(real v, int frac);
        real s;
        s = v * (2.0 ** frac);
        if (s >= 0.0) return longint'($rtoi(s + 0.5));
        else          return longint'($rtoi(s - 0.5));
    endfunction

    // Integer power of a real base, used for the comb weight r^N.
    function automatic real pow_n(real b, int e);
        real acc;
        acc = 1.0;
        for (int i = 0; i < e; i++) acc = acc * b;
        return acc;
    endfunction

    // Drop 'frac' fractional bits: add half an LSB, then floor.
    function automatic longint rnd_shift(longint v, int frac);
        return (v + (longint'(1) <<< (frac - 1))) >>> frac;
    endfunction

    // Clip a value to the signed range of a w-bit word.
    function automatic longint clip(longint v, int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/sdft_delay.sv
// Circular N-deep sample history for the comb stage.
// dout is the sample written N strobes ago; until N strobes have been
// stored since reset it reads as zero, so the memory needs no reset.
// Assumes en is a single-cycle strobe qualified by the caller.
module sdft_delay #(
    parameter int W = 20,
    parameter int N = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    localparam int AW = (N > 1) ? $clog2(N) : 1;
    localparam logic [AW-1:0] LAST = AW'(N - 1);

    logic signed [W-1:0] mem [N];
    logic [AW-1:0]       wptr;
    logic                primed;

    // Store the incoming sample over the oldest one.
    always_ff @(posedge clk) begin
        if (en) mem[wptr] <= din;
    end

    // Advance the write pointer; flag once the history is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            primed <= 1'b0;
        end else if (en) begin
            wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (wptr == LAST) primed <= 1'b1;
        end
    end

    assign dout = primed ? mem[wptr] : '0;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + 1'b1))); // R5
    AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(wptr)); // R3
    AST_PRIMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        primed |=> primed); // R5

endmodule

// File: rtl/sdft_comb.sv
// Damped comb stage: c = x - RN*x_delayed, where RN = r^N quantised.
// The result is rounded and saturated, then registered on each strobe.
// Assumes r < 1 so that RN < 1 and the product stays within range.
module sdft_comb
    import sdft_pkg::*;
#(
    parameter int  W = 20,
    parameter int  F = 18,
    parameter int  N = 512,
    parameter real R = 0.9997
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] x,
    input  logic signed [W-1:0] xd,
    output logic signed [W-1:0] c_q
);
    localparam longint RN_Q = q_of(pow_n(R, N), F);

    logic signed [W-1:0] c_next;

    // Subtract the damped old sample from the new one.
    always_comb begin
        c_next = W'(clip(longint'(x) - rnd_shift(RN_Q * longint'(xd), F), W));
    end

    // Hold the comb result for the resonator's next step.
    always_ff @(posedge clk) begin
        if (!rst_n)  c_q <= '0;
        else if (en) c_q <= c_next;
    end

    AST_COMB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(c_q)); // R3

endmodule

// File: rtl/sdft_rotator.sv
// Complex multiply by the fixed twiddle W = r*cos(2pi k/N) + j r*sin(2pi k/N)
// using four real products. Each output is rounded to F fractional bits and
// saturated to W bits. Purely combinational.
module sdft_rotator
    import sdft_pkg::*;
#(
    parameter int  W = 20,
    parameter int  F = 18,
    parameter int  N = 512,
    parameter int  K = 1,
    parameter real R = 0.9997
) (
    input  logic signed [W-1:0] s_re,
    input  logic signed [W-1:0] s_im,
    output logic signed [W-1:0] r_re,
    output logic signed [W-1:0] r_im
);
    localparam real    ANG = 2.0 * PI_R * real'(K) / real'(N);
    localparam longint WR  = q_of(R * $cos(ANG), F);
    localparam longint WI  = q_of(R * $sin(ANG), F);

    // Four products combined into the rotated, damped pair.
    always_comb begin
        r_re = W'(clip(rnd_shift(WR * longint'(s_re) - WI * longint'(s_im), F), W));
        r_im = W'(clip(rnd_shift(WI * longint'(s_re) + WR * longint'(s_im), F), W));
    end

endmodule

// File: rtl/sdft_bin.sv
// Damped sliding DFT for a single fixed bin k. Each strobe writes the sample
// into the history and updates the comb, and the resonator computes
// y = W*(y + c_prev). Outputs become valid one cycle after each strobe.
// Assumes the input is scaled so that the resonator stays within +/-2.
module sdft_bin
    import sdft_pkg::*;
#(
    parameter int  W = 20,
    parameter int  F = 18,
    parameter int  N = 512,
    parameter int  K = 1,
    parameter real R = 0.9997
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_en,
    input  logic signed [W-1:0] smp_in,
    output logic signed [W-1:0] bin_re,
    output logic signed [W-1:0] bin_im,
    output logic                bin_valid
);
    logic signed [W-1:0] old_smp;
    logic signed [W-1:0] comb_q;
    logic signed [W-1:0] sum_re;
    logic signed [W-1:0] rot_re;
    logic signed [W-1:0] rot_im;

    sdft_delay #(.W(W), .N(N)) u_delay (
        .clk(clk), .rst_n(rst_n), .en(smp_en),
        .din(smp_in), .dout(old_smp)
    );

    sdft_comb #(.W(W), .F(F), .N(N), .R(R)) u_comb (
        .clk(clk), .rst_n(rst_n), .en(smp_en),
        .x(smp_in), .xd(old_smp), .c_q(comb_q)
    );

    // Resonator input: previous state plus previous comb output (real only).
    always_comb begin
        sum_re = W'(clip(longint'(bin_re) + longint'(comb_q), W));
    end

    sdft_rotator #(.W(W), .F(F), .N(N), .K(K), .R(R)) u_rot (
        .s_re(sum_re), .s_im(bin_im), .r_re(rot_re), .r_im(rot_im)
    );

    // Resonator state register, which also drives the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_re <= '0;
            bin_im <= '0;
        end else if (smp_en) begin
            bin_re <= rot_re;
            bin_im <= rot_im;
        end
    end

    // One-cycle valid flag following each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) bin_valid <= 1'b0;
        else        bin_valid <= smp_en;
    end

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en |=> bin_valid); // R2
    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bin_valid |-> $past(smp_en)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> ($stable(bin_re) && $stable(bin_im))); // R3

endmodule

// File: tb/sdft_bin_test.sv
`timescale 1ns/1ps
module sdft_bin_test;
    localparam int  W = 20;
    localparam int  F = 18;
    localparam int  N = 16;
    localparam int  K = 1;
    localparam real R = 0.9997;
    localparam real PI = 3.14159265358979323846;
    localparam int  NV = 24;

    localparam int VX [NV] = '{26214, -13107, 5000, 0, 65536, -65536, 1234, 30000,
                               -20000, 7, 99999, -1, 40000, 40000, 40000, -52428,
                               12345, 0, 0, 8000, -8000, 60000, -60000, 26214};
    localparam bit VE [NV] = '{1, 1, 1, 0, 1, 1, 0, 1,
                               1, 1, 0, 1, 1, 1, 1, 1,
                               0, 1, 1, 1, 1, 1, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_en = 1'b0;
    logic signed [W-1:0] smp_in = '0;
    logic signed [W-1:0] bin_re, bin_im;
    logic bin_valid;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sdft_bin #(.W(W), .F(F), .N(N), .K(K), .R(R)) uut (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_in(smp_in),
        .bin_re(bin_re), .bin_im(bin_im), .bin_valid(bin_valid)
    );

    // Reference model state, built from the requirements
    longint m_re, m_im, m_c;
    longint hist [N];
    int     cnt, hp;
    longint cre, cim, crn;

    function automatic longint qr(real v);
        real s;
        s = v * 262144.0;
        return (s >= 0.0) ? longint'($rtoi(s + 0.5)) : longint'($rtoi(s - 0.5));
    endfunction

    function automatic longint satw(longint v);
        if (v > 524287)  return 524287;
        if (v < -524288) return -524288;
        return v;
    endfunction

    function automatic longint rnd(longint p);
        return (p + 131072) >>> 18;
    endfunction

    task automatic model_reset();
        m_re = 0; m_im = 0; m_c = 0; cnt = 0; hp = 0;
        for (int i = 0; i < N; i++) hist[i] = 0;
    endtask

    task automatic model_step(input longint x);
        longint sr, si, xd;
        sr = satw(m_re + m_c);
        si = m_im;
        m_re = satw(rnd(cre * sr - cim * si));
        m_im = satw(rnd(cim * sr + cre * si));
        xd = (cnt >= N) ? hist[hp] : 0;
        m_c = satw(x - rnd(crn * xd));
        hist[hp] = x;
        hp = (hp + 1) % N;
        cnt++;
    endtask

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        smp_en = 1'b1;
        smp_in = 20'sd77777;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        smp_en = 1'b0;
        rst_n = 1'b1;
        model_reset();
    endtask

    // Apply one cycle; compare the outputs with the model after the edge.
    task automatic step(input longint x, input bit e, input string tag);
        smp_in = W'(x);
        smp_en = e;
        @(posedge clk);
        #1;
        smp_en = 1'b0;
        if (e) model_step(x);
        check("R2 valid", longint'(bin_valid), longint'(e));
        check(tag, longint'(bin_re), m_re);
        check(tag, longint'(bin_im), m_im);
    endtask

    function automatic longint tone(real amp, int kk, int n);
        return qr(amp * $cos(2.0 * PI * real'(kk) * real'(n) / real'(N)));
    endfunction

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        longint hold_re, hold_im, mag_on, mag_off;
        int sat_hits;
        cre = qr(R * $cos(2.0 * PI * real'(K) / real'(N)));
        cim = qr(R * $sin(2.0 * PI * real'(K) / real'(N)));
        crn = 1;
        begin
            real p;
            p = 1.0;
            for (int i = 0; i < N; i++) p = p * R;
            crn = qr(p);
        end

        // R1: reset state, with a strobe and data present during reset
        do_reset();
        check("R1 re", longint'(bin_re), 0);
        check("R1 im", longint'(bin_im), 0);
        check("R1 valid", longint'(bin_valid), 0);

        // Table walk: R4 recursion, R5 comb beyond N strobes, R3 idle entries
        for (int i = 0; i < NV; i++) step(VX[i], VE[i], "R4 table");
        for (int i = 0; i < NV; i++) step(VX[NV-1-i], 1'b1, "R5 table");

        // R3: idle cycles with varying input change nothing
        hold_re = longint'(bin_re);
        hold_im = longint'(bin_im);
        for (int i = 0; i < 6; i++) step(100000 - i * 30000, 1'b0, "R3 idle");
        check("R3 hold re", longint'(bin_re), hold_re);
        check("R3 hold im", longint'(bin_im), hold_im);

        // R8: impulse response cancels after N+1 strobes
        do_reset();
        step(65536, 1'b1, "R5 impulse");
        for (int i = 0; i < 2 * N + 8; i++) step(0, 1'b1, "R5 impulse tail");
        checks++;
        if (bin_re > 64 || bin_re < -64 || bin_im > 64 || bin_im < -64) begin
            fails++;
            $display("FAIL R8: actual %0d,%0d expected |x|<=64", bin_re, bin_im);
        end

        // R7: on-bin tone grows, off-bin tone stays small
        do_reset();
        for (int n = 0; n < 3 * N; n++) step(tone(0.05, K, n), 1'b1, "R7 on-bin");
        mag_on = (bin_re < 0 ? -longint'(bin_re) : longint'(bin_re)) +
                 (bin_im < 0 ? -longint'(bin_im) : longint'(bin_im));
        do_reset();
        for (int n = 0; n < 3 * N; n++) step(tone(0.05, 3, n), 1'b1, "R7 off-bin");
        mag_off = (bin_re < 0 ? -longint'(bin_re) : longint'(bin_re)) +
                  (bin_im < 0 ? -longint'(bin_im) : longint'(bin_im));
        checks++;
        if (mag_on <= 4 * mag_off + 1000) begin
            fails++;
            $display("FAIL R7: actual on=%0d off=%0d expected on >> off", mag_on, mag_off);
        end

        // R6: overdriven tone saturates and still matches the model
        do_reset();
        sat_hits = 0;
        for (int n = 0; n < 3 * N; n++) begin
            step(tone(1.5, K, n), 1'b1, "R6 saturate");
            if (bin_re == 20'sh7FFFF || bin_re == -20'sh80000 ||
                bin_im == 20'sh7FFFF || bin_im == -20'sh80000) sat_hits++;
        end
        checks++;
        if (sat_hits == 0) begin
            fails++;
            $display("FAIL R6: actual 0 saturated outputs expected >0");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule